// File: doc/BRIEF.md
# Manchester Framed Word Receiver

This block recovers 16-bit words from a serial line that carries short, UART-style bursts. Each bit is Manchester coded and the block samples the line on a clock at sixteen times the bit rate. The line rests high between bursts. A burst opens with a start bit, then carries the data bits with the most significant first, and ends with a stop bit. The start and stop bits are always coded as ones. A one is a low half followed by a high half, so it has a rising transition at mid-bit. A zero is the reverse and has a falling transition at mid-bit. The line first passes through a two-flop synchroniser. A falling edge while idle opens a frame. From then on the block samples each half of every bit near its centre and re-aligns its tick counter on each mid-bit transition, so it tolerates a modest rate mismatch.

Any bit whose two halves read the same, a start bit that does not decode as a one, or a stop bit that does not decode as a one makes the block drop the word and flag an error. It then ignores the line until the line has been high for three whole bit periods. That long high run is the resynchronisation condition and is reported on its own pin. The word leaves the block on a plain one-cycle strobe. There is no back-pressure: the consumer must take the word in the cycle the strobe is high, and the word stays on the data pins until the next good frame replaces it.

Top module: `manchester_word_rx`

## Requirements
- R1: A synchronous reset, whether applied from idle or mid-frame, drives rx_valid, rx_err and rx_resync to 0 and rx_data to 0, and leaves the receiver idle, ready for the next start edge.
- R2: The line is read as: idle high, then a falling edge while idle that opens a start bit, then 16 data bits with the most significant bit first, then a stop bit. Each bit lasts 16 clock ticks. A one is 8 ticks low then 8 ticks high. A zero is 8 ticks high then 8 ticks low.
- R3: When a frame decodes without fault, rx_data shows the assembled word and rx_valid is high for exactly one clock cycle.
- R4: rx_data changes only in the cycle rx_valid is high. A faulty frame leaves it unchanged.
- R5: A data bit whose two half samples are equal raises rx_err for exactly one cycle, and rx_valid does not rise for that frame.
- R6: A start bit or stop bit that does not decode as a one (halves equal or coded as a zero) raises rx_err for one cycle, and no word is delivered.
- R7: After an error, no word is delivered until the line has been high for 48 consecutive ticks. A well-formed frame sent before that is ignored.
- R8: rx_resync pulses for one cycle once the line has been high for 48 consecutive ticks. It pulses only once per high run. A partial frame is abandoned and the receiver returns to idle.
- R9: Frames whose bit period is 15 or 17 ticks decode correctly, because the tick counter re-aligns on every mid-bit transition.
- R10: Two frames sent back to back with no idle gap are both delivered, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, sixteen times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial line, idles high |
| rx_data | output | 16 | Last word received without fault |
| rx_valid | output | 1 | One-cycle strobe marking a new word on rx_data |
| rx_err | output | 1 | One-cycle pulse on a coding or framing fault |
| rx_resync | output | 1 | One-cycle pulse after three bit periods of continuous high |

## Verification
The assertions assume that the line changes no faster than once per half-bit around the sampling points. They also assume that mid-bit edges fall within three ticks of the nominal centre, so the one-cycle strobes and the bit counter stay in their legal range. The stimulus drives the line only on falling clock edges. It builds every bit from two half-bit runs of 7 to 9 ticks, and it inserts faults only by making whole halves equal or by inverting a whole stop bit. Between cases it idles the line long enough either to close a frame or to force a resynchronisation, so each case starts from a known idle state.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP  = 3'd3,
    RX_HOLD  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mrx_high_watch.sv
module mrx_high_watch #(
  parameter int TICKS_PER_BIT = 16,
  parameter int RESYNC_BITS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  output logic resync_o
);
  localparam int LIMIT = TICKS_PER_BIT * RESYNC_BITS;
  localparam int RW    = $clog2(LIMIT + 1);
  localparam logic [RW-1:0] LIM_V = RW'(LIMIT);
  localparam logic [RW-1:0] PRE_V = RW'(LIMIT - 1);

  logic [RW-1:0] run_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= line_s && (run_q == PRE_V);
      if (!line_s)             run_q <= '0;
      else if (run_q != LIM_V) run_q <= run_q + 1'b1;
    end
  end

  assign resync_o = pulse_q;

  a_r8_resync_single: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  a_r8_resync_needs_high: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> $past(line_s));
endmodule

// File: rtl/mrx_core.sv
module mrx_core
  import mrx_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_s,
  input  logic              resync,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int CW   = $clog2(TICKS_PER_BIT);
  localparam int HALF = TICKS_PER_BIT / 2;
  localparam int QTR  = TICKS_PER_BIT / 4;
  localparam int NW   = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] T_S1   = CW'(QTR);
  localparam logic [CW-1:0] T_S2   = CW'(HALF + QTR);
  localparam logic [CW-1:0] T_WLO  = CW'(HALF - 3);
  localparam logic [CW-1:0] T_WHI  = CW'(HALF + 3);
  localparam logic [CW-1:0] T_MID1 = CW'(HALF + 1);
  localparam logic [CW-1:0] T_LAST = CW'(TICKS_PER_BIT - 1);
  localparam logic [NW-1:0] N_LAST = NW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     tick_q;
  logic [NW-1:0]     cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              line_d_q;
  logic              half1_q;

  logic fall, trans, in_window, halves_ok;
  assign fall      = line_d_q && !line_s;
  assign trans     = line_d_q ^ line_s;
  assign in_window = (tick_q >= T_WLO) && (tick_q <= T_WHI);
  assign halves_ok = (half1_q != line_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RX_IDLE;
      tick_q   <= '0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      line_d_q <= 1'b1;
      half1_q  <= 1'b1;
    end else begin
      line_d_q <= line_s;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      if (resync && state_q != RX_IDLE) begin
        state_q <= RX_IDLE;
      end else begin
        case (state_q)
          RX_IDLE: begin
            if (fall) begin
              state_q <= RX_START;
              tick_q  <= CW'(1);
              cnt_q   <= '0;
            end
          end
          RX_START, RX_DATA, RX_STOP: begin
            if (trans && in_window)     tick_q <= T_MID1;
            else if (tick_q == T_LAST)  tick_q <= '0;
            else                        tick_q <= tick_q + 1'b1;
            if (tick_q == T_S1) half1_q <= line_s;
            if (tick_q == T_S2) begin
              if (!halves_ok) begin
                err_o   <= 1'b1;
                state_q <= RX_HOLD;
              end else begin
                unique case (state_q)
                  RX_START: begin
                    if (line_s) state_q <= RX_DATA;
                    else begin
                      err_o   <= 1'b1;
                      state_q <= RX_HOLD;
                    end
                  end
                  RX_DATA: begin
                    shreg_q <= {shreg_q[DATA_W-2:0], line_s};
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == N_LAST) state_q <= RX_STOP;
                  end
                  default: begin
                    if (line_s) begin
                      data_o  <= shreg_q;
                      valid_o <= 1'b1;
                      state_q <= RX_IDLE;
                    end else begin
                      err_o   <= 1'b1;
                      state_q <= RX_HOLD;
                    end
                  end
                endcase
              end
            end
          end
          default: state_q <= RX_HOLD;
        endcase
      end
    end
  end

  // R3: the word strobe lasts one cycle
  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R5: the fault pulse lasts one cycle
  a_r5_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  // R6: a frame cannot both deliver and fault
  a_r6_no_valid_with_err: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && err_o));
  // R4: the word moves only with its strobe
  a_r4_data_moves_with_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_o) |-> valid_o);
  // R7: nothing is delivered while waiting for resynchronisation
  a_r7_hold_blocks_valid: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_HOLD) |=> !valid_o);
  // R2: the bit counter never passes the word width
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= NW'(DATA_W));
endmodule

// File: rtl/manchester_word_rx.sv
module manchester_word_rx #(
  parameter int DATA_W        = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int RESYNC_BITS   = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_err,
  output logic              rx_resync
);
  logic line_s;

  mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .dout(line_s)
  );

  mrx_high_watch #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .RESYNC_BITS  (RESYNC_BITS)
  ) u_watch (
    .clk     (clk),
    .rst     (rst),
    .line_s  (line_s),
    .resync_o(rx_resync)
  );

  mrx_core #(
    .DATA_W       (DATA_W),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .line_s (line_s),
    .resync (rx_resync),
    .data_o (rx_data),
    .valid_o(rx_valid),
    .err_o  (rx_err)
  );
endmodule

// File: tb/manchester_word_rx_bench.sv
module manchester_word_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // vector: {data[15:0], kind[1:0], pos[3:0], period[4:0]}
  // kind 0 good, 1 bad data bit at pos (0 = MSB), 2 bad stop, 3 bad start
  localparam logic [26:0] VEC [NVEC] = '{
    {16'hA5C3, 2'd0, 4'd0,  5'd16},
    {16'h0000, 2'd0, 4'd0,  5'd16},
    {16'hFFFF, 2'd0, 4'd0,  5'd16},
    {16'h8001, 2'd0, 4'd0,  5'd15},
    {16'h7FFE, 2'd0, 4'd0,  5'd17},
    {16'h1234, 2'd1, 4'd0,  5'd16},
    {16'hBEEF, 2'd1, 4'd15, 5'd16},
    {16'h5555, 2'd2, 4'd0,  5'd16},
    {16'hCAFE, 2'd3, 4'd0,  5'd16},
    {16'h3C96, 2'd0, 4'd0,  5'd17}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic [15:0] rx_data;
  logic        rx_valid, rx_err, rx_resync;

  int n_chk = 0, n_bad = 0;
  int n_valid = 0, n_err = 0, n_resync = 0, n_dbl = 0;
  logic [15:0] got [4];
  logic prev_valid = 1'b0;
  logic [15:0] last_good = 16'h0000;

  manchester_word_rx u_manchester_word_rx (
    .clk(clk), .rst(rst), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err), .rx_resync(rx_resync)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (n_valid < 4) got[n_valid] = rx_data;
        n_valid = n_valid + 1;
        if (prev_valid) n_dbl = n_dbl + 1;
      end
      if (rx_err) n_err = n_err + 1;
      if (rx_resync) n_resync = n_resync + 1;
    end
    prev_valid = rx_valid;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_valid = 0; n_err = 0; n_resync = 0; n_dbl = 0;
  endtask

  task automatic hold(input logic lvl, input int n);
    rx_line = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int per);
    hold(~b, per - per/2);
    hold(b, per/2);
  endtask

  task automatic send_frame(input logic [15:0] d, input int kind, input int pos, input int per);
    if (kind == 3) begin hold(1'b0, per - per/2); hold(1'b0, per/2); end
    else send_bit(1'b1, per);
    for (int i = 0; i < 16; i++) begin
      if (kind == 1 && i == pos) begin hold(1'b1, per - per/2); hold(1'b1, per/2); end
      else send_bit(d[15-i], per);
    end
    if (kind == 2) send_bit(1'b0, per);
    else send_bit(1'b1, per);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: state straight out of reset
    chk(rx_valid == 1'b0 && rx_err == 1'b0 && rx_resync == 1'b0, "R1 reset flags",
        {rx_valid, rx_err, rx_resync}, 0);
    chk(rx_data == 16'h0, "R1 reset data", rx_data, 0);
    rst = 1'b0;
    clear_counts();
    hold(1'b1, 130);
    // R8: one resync pulse per long high run
    chk(n_resync == 1, "R8 single resync on long idle", n_resync, 1);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] d;
      int kind, pos, per;
      d = VEC[v][26:11]; kind = int'(VEC[v][10:9]); pos = int'(VEC[v][8:5]); per = int'(VEC[v][4:0]);
      clear_counts();
      send_frame(d, kind, pos, per);
      if (kind == 0) begin
        hold(1'b1, 20);
        // R2 R3 R9: good frame delivered, MSB first, period 15/16/17
        chk(n_valid == 1 && n_err == 0, "R3 one strobe per good frame", n_valid, 1);
        chk(got[0] == d && rx_data == d, "R2 word value", got[0], d);
        last_good = d;
      end else begin
        hold(1'b1, 60);
        if (kind == 1) chk(n_err == 1 && n_valid == 0, "R5 bad data bit", n_err, 1);
        else chk(n_err == 1 && n_valid == 0, "R6 bad start/stop", n_err, 1);
        chk(rx_data == last_good, "R4 data kept on fault", rx_data, last_good);
        chk(n_resync == 1, "R8 resync after fault", n_resync, 1);
      end
    end

    // R7: good frame too soon after a fault is ignored
    clear_counts();
    send_frame(16'h4321, 1, 3, 16);
    hold(1'b1, 20);
    send_frame(16'h6789, 0, 0, 16);
    hold(1'b1, 60);
    chk(n_valid == 0 && n_err == 1, "R7 ignored before resync", n_valid, 0);
    clear_counts();
    send_frame(16'h6789, 0, 0, 16);
    hold(1'b1, 20);
    chk(n_valid == 1 && rx_data == 16'h6789, "R7 accepted after resync", rx_data, 16'h6789);

    // R10: back-to-back frames
    clear_counts();
    send_frame(16'h1357, 0, 0, 16);
    send_frame(16'h2468, 0, 0, 16);
    hold(1'b1, 20);
    chk(n_valid == 2, "R10 two strobes", n_valid, 2);
    chk(got[0] == 16'h1357 && got[1] == 16'h2468, "R10 order", {got[0], got[1]}, 32'h13572468);

    // R8: partial frame abandoned, then recovery
    clear_counts();
    send_bit(1'b1, 16);
    for (int i = 0; i < 5; i++) send_bit(i[0], 16);
    hold(1'b1, 70);
    chk(n_resync == 1 && n_valid == 0, "R8 partial abandoned", n_resync, 1);
    clear_counts();
    send_frame(16'h0F0F, 0, 0, 16);
    hold(1'b1, 20);
    chk(n_valid == 1 && rx_data == 16'h0F0F, "R8 recovery frame", rx_data, 16'h0F0F);

    // R1: reset mid-frame
    send_bit(1'b1, 16);
    for (int i = 0; i < 6; i++) send_bit(1'b0, 16);
    rst = 1'b1;
    rx_line = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_data == 16'h0 && !rx_valid && !rx_err, "R1 mid-frame reset", rx_data, 0);
    rst = 1'b0;
    hold(1'b1, 8);
    clear_counts();
    send_frame(16'h9ABC, 0, 0, 16);
    hold(1'b1, 20);
    chk(n_valid == 1 && rx_data == 16'h9ABC, "R1 idle after reset", rx_data, 16'h9ABC);

    // R3: strobe never wider than one cycle across the whole run
    chk(n_dbl == 0, "R3 no double strobe", n_dbl, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule